// File: doc/BRIEF.md
# Per-Port Receive Statistics Counters

This block holds the receive statistics for every port of a multi-port packet input unit. When a packet ends, the receive logic presents one event. The event carries the port number, the frame length in bytes with the FCS included, and a set of qualifier flags: FCS or alignment error, receive error, drop, multicast, broadcast, and a flag that says the packet was parsed from layer 2. The block derives an increment for each of 21 counters from that event and adds the increments to the counters of the addressed port in one cycle.

Software-facing logic reads the counters through a read port. It names a port and a counter index and gets the value one cycle later. A global read-clear level, when high during a read, zeroes the counter being read. Counters saturate and never wrap. Frame reception and error detection are outside this block.

Top module: `rxstat_counters`

## Requirements
- R1: Each packet whose length is between MIN_LEN and MAX_LEN falls into exactly one histogram bucket. The buckets are: length ≤64 (index 6), 65–127 (7), 128–255 (8), 256–511 (9), 512–1023 (10), 1024–1518 (11), and 1519 up to MAX_LEN (12). Runts and oversize packets fall into no bucket.
- R2: Broadcast (index 5) counts packets with both the broadcast flag and the layer-2 parse flag set. Multicast (index 4) counts packets with the multicast flag and the layer-2 flag set and the broadcast flag clear. Without the layer-2 flag, neither counter moves.
- R3: A packet shorter than MIN_LEN counts in index 14 when its FCS is good and in index 15 when its FCS is bad. A packet longer than MAX_LEN counts in index 16 when its FCS is good and in index 17 when its FCS is bad.
- R4: Every packet with the FCS/alignment error flag set counts in index 13, whatever its length.
- R5: Dropped packets add 1 to index 0 and their length to index 1. Packets that are not dropped add 1 to index 2 and their length to index 3.
- R6: Packets without a receive error add 1 to index 18. Every packet adds its length to index 19, which is OCT_W bits wide. Packets with a receive error add 1 to index 20, which is ERR_W bits wide.
- R7: A read accepted at a clock edge raises rd_valid for the following cycle. rd_data then holds the counter value as it stood before that edge. rd_valid is low in every other cycle, including after reset, and all counters reset to zero.
- R8: When rd_clr is high during a read, the counter that was read becomes zero. When rd_clr is low, the counter is left unchanged.
- R9: If a read with rd_clr high and an event hit the same counter at the same edge, the read returns the value without the event's increment. The counter is left holding only that increment.
- R10: Counters saturate at their all-ones value and do not wrap. Indices 19 and 20 saturate at OCT_W and ERR_W bits; all other counters saturate at PKT_W bits.
- R11: Events whose port number is NPORTS or above change no counter. Reads of such a port, or of a counter index of 21 or above, return zero.
- R12: An event changes only the counters of its own port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_valid | input | 1 | End-of-packet event strobe |
| ev_port | input | PORT_W | Port of the event |
| ev_len | input | LEN_W | Frame length in bytes including FCS |
| ev_fcs_err | input | 1 | FCS or alignment error |
| ev_rx_err | input | 1 | Receive error |
| ev_drop | input | 1 | Packet marked for drop |
| ev_mcast | input | 1 | Layer-2 multicast destination |
| ev_bcast | input | 1 | Layer-2 broadcast destination |
| ev_l2 | input | 1 | Packet parsed from layer 2 |
| rd_en | input | 1 | Read request |
| rd_clr | input | 1 | Global read-clear level |
| rd_port | input | PORT_W | Port to read |
| rd_sel | input | 5 | Counter index to read |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | OCT_W | Counter value returned |

## Verification
The assertions check several properties in every cycle. They check the read handshake timing and the saturation ceilings seen on returned values. They check that reads of nonexistent ports return zero. They also check that a cleared counter reads back as zero when no event touched it in between. The bench scenarios are what show correct classification of each event into its counters: the histogram edges, the layer-2 gating of multicast and broadcast, and the FCS split of runts and oversize packets. The same holds for the result when a clear collides with an event, and for saturation of a counter that sums lengths.

// File: rtl/rxstat_pkg.sv
package rxstat_pkg;
    localparam int NCNT  = 21;
    localparam int SEL_W = 5;

    typedef enum logic [SEL_W-1:0] {
        C_DROP_PKT = 5'd0,  C_DROP_OCT = 5'd1,  C_PKT      = 5'd2,
        C_OCT      = 5'd3,  C_MCAST    = 5'd4,  C_BCAST    = 5'd5,
        C_H64      = 5'd6,  C_H127     = 5'd7,  C_H255     = 5'd8,
        C_H511     = 5'd9,  C_H1023    = 5'd10, C_H1518    = 5'd11,
        C_HMAX     = 5'd12, C_FCS      = 5'd13, C_RUNT     = 5'd14,
        C_RUNT_FCS = 5'd15, C_OVER     = 5'd16, C_OVER_FCS = 5'd17,
        C_INB_PKT  = 5'd18, C_INB_OCT  = 5'd19, C_INB_ERR  = 5'd20
    } cnt_e;
endpackage

// File: rtl/rxstat_classify.sv
module rxstat_classify
    import rxstat_pkg::*;
#(
    parameter int LEN_W   = 14,
    parameter int CW      = 48,
    parameter int MIN_LEN = 64,
    parameter int MAX_LEN = 1536
) (
    input  logic [LEN_W-1:0]         ev_len,
    input  logic                     ev_fcs_err,
    input  logic                     ev_rx_err,
    input  logic                     ev_drop,
    input  logic                     ev_mcast,
    input  logic                     ev_bcast,
    input  logic                     ev_l2,
    output logic [NCNT-1:0][CW-1:0]  amt
);
    logic [CW-1:0] one, octs;
    logic          runt, over, mid;

    always_comb begin
        one  = CW'(1);
        octs = CW'(ev_len);
        runt = 32'(ev_len) < MIN_LEN;
        over = 32'(ev_len) > MAX_LEN;
        mid  = !runt && !over;
        amt  = '0;
        amt[C_DROP_PKT] = ev_drop  ? one  : '0;
        amt[C_DROP_OCT] = ev_drop  ? octs : '0;
        amt[C_PKT]      = !ev_drop ? one  : '0;
        amt[C_OCT]      = !ev_drop ? octs : '0;
        amt[C_MCAST]    = (ev_l2 && ev_mcast && !ev_bcast) ? one : '0;
        amt[C_BCAST]    = (ev_l2 && ev_bcast) ? one : '0;
        if (mid) begin
            if      (32'(ev_len) <= 64)   amt[C_H64]   = one;
            else if (32'(ev_len) <= 127)  amt[C_H127]  = one;
            else if (32'(ev_len) <= 255)  amt[C_H255]  = one;
            else if (32'(ev_len) <= 511)  amt[C_H511]  = one;
            else if (32'(ev_len) <= 1023) amt[C_H1023] = one;
            else if (32'(ev_len) <= 1518) amt[C_H1518] = one;
            else                          amt[C_HMAX]  = one;
        end
        amt[C_FCS]      = ev_fcs_err ? one : '0;
        amt[C_RUNT]     = (runt && !ev_fcs_err) ? one : '0;
        amt[C_RUNT_FCS] = (runt &&  ev_fcs_err) ? one : '0;
        amt[C_OVER]     = (over && !ev_fcs_err) ? one : '0;
        amt[C_OVER_FCS] = (over &&  ev_fcs_err) ? one : '0;
        amt[C_INB_PKT]  = !ev_rx_err ? one : '0;
        amt[C_INB_OCT]  = octs;
        amt[C_INB_ERR]  = ev_rx_err ? one : '0;
    end
endmodule

// File: rtl/rxstat_bank.sv
module rxstat_bank
    import rxstat_pkg::*;
#(
    parameter int CW    = 48,
    parameter int PKT_W = 32,
    parameter int ERR_W = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     hit,
    input  logic [NCNT-1:0][CW-1:0]  amt,
    input  logic [NCNT-1:0]          clr_sel,
    output logic [NCNT-1:0][CW-1:0]  cnt
);
    localparam logic [CW-1:0] LIM_PKT = {{(CW-PKT_W){1'b0}}, {PKT_W{1'b1}}};
    localparam logic [CW-1:0] LIM_ERR = {{(CW-ERR_W){1'b0}}, {ERR_W{1'b1}}};
    localparam logic [CW-1:0] LIM_OCT = {CW{1'b1}};

    typedef struct packed {
        logic [NCNT-1:0][CW-1:0] cnt;
    } bank_t;

    bank_t st_d, st_q;

    always_comb begin
        logic [CW-1:0] base;
        logic [CW-1:0] lim;
        logic [CW:0]   sum;
        st_d = st_q;
        for (int i = 0; i < NCNT; i++) begin
            base = clr_sel[i] ? '0 : st_q.cnt[i];
            if (i == int'(C_INB_OCT))      lim = LIM_OCT;
            else if (i == int'(C_INB_ERR)) lim = LIM_ERR;
            else                           lim = LIM_PKT;
            sum = {1'b0, base} + {1'b0, (hit ? amt[i] : {CW{1'b0}})};
            st_d.cnt[i] = (sum > {1'b0, lim}) ? lim : sum[CW-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt = st_q.cnt;
endmodule

// File: rtl/rxstat_counters.sv
module rxstat_counters
    import rxstat_pkg::*;
#(
    parameter int NPORTS  = 48,
    parameter int LEN_W   = 14,
    parameter int PKT_W   = 32,
    parameter int OCT_W   = 48,
    parameter int ERR_W   = 16,
    parameter int MIN_LEN = 64,
    parameter int MAX_LEN = 1536,
    localparam int PORT_W = (NPORTS > 1) ? $clog2(NPORTS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ev_valid,
    input  logic [PORT_W-1:0] ev_port,
    input  logic [LEN_W-1:0]  ev_len,
    input  logic              ev_fcs_err,
    input  logic              ev_rx_err,
    input  logic              ev_drop,
    input  logic              ev_mcast,
    input  logic              ev_bcast,
    input  logic              ev_l2,
    input  logic              rd_en,
    input  logic              rd_clr,
    input  logic [PORT_W-1:0] rd_port,
    input  logic [SEL_W-1:0]  rd_sel,
    output logic              rd_valid,
    output logic [OCT_W-1:0]  rd_data
);
    localparam int CW = OCT_W;

    typedef struct packed {
        logic          rd_valid;
        logic [CW-1:0] rd_data;
    } rd_t;

    rd_t                     st_d, st_q;
    logic [NCNT-1:0][CW-1:0] amt;
    logic [NCNT-1:0][CW-1:0] bank_cnt [NPORTS];
    logic [NCNT-1:0]         sel_onehot;
    logic                    port_ok, sel_ok;

    rxstat_classify #(
        .LEN_W(LEN_W), .CW(CW), .MIN_LEN(MIN_LEN), .MAX_LEN(MAX_LEN)
    ) u_classify (
        .ev_len(ev_len), .ev_fcs_err(ev_fcs_err), .ev_rx_err(ev_rx_err),
        .ev_drop(ev_drop), .ev_mcast(ev_mcast), .ev_bcast(ev_bcast),
        .ev_l2(ev_l2), .amt(amt)
    );

    assign port_ok    = 32'(rd_port) < NPORTS;
    assign sel_ok     = 32'(rd_sel) < NCNT;
    assign sel_onehot = NCNT'(1) << rd_sel;

    for (genvar p = 0; p < NPORTS; p++) begin : g_port
        logic            hit;
        logic [NCNT-1:0] clr_sel;
        assign hit     = ev_valid && (ev_port == PORT_W'(p));
        assign clr_sel = (rd_en && rd_clr && sel_ok && rd_port == PORT_W'(p))
                         ? sel_onehot : '0;
        rxstat_bank #(
            .CW(CW), .PKT_W(PKT_W), .ERR_W(ERR_W)
        ) u_bank (
            .clk(clk), .rst_n(rst_n), .hit(hit), .amt(amt),
            .clr_sel(clr_sel), .cnt(bank_cnt[p])
        );
    end

    always_comb begin
        st_d          = st_q;
        st_d.rd_valid = rd_en;
        if (rd_en) begin
            st_d.rd_data = (port_ok && sel_ok) ? bank_cnt[rd_port][rd_sel] : '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rd_valid = st_q.rd_valid;
    assign rd_data  = st_q.rd_data;
endmodule

// File: rtl/rxstat_checker.sv
module rxstat_checker
    import rxstat_pkg::*;
#(
    parameter int NPORTS = 48,
    parameter int PORT_W = 6,
    parameter int PKT_W  = 32,
    parameter int OCT_W  = 48,
    parameter int ERR_W  = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ev_valid,
    input logic [PORT_W-1:0] ev_port,
    input logic              rd_en,
    input logic              rd_clr,
    input logic [PORT_W-1:0] rd_port,
    input logic [SEL_W-1:0]  rd_sel,
    input logic              rd_valid,
    input logic [OCT_W-1:0]  rd_data
);
    localparam logic [OCT_W-1:0] LIM_PKT = {{(OCT_W-PKT_W){1'b0}}, {PKT_W{1'b1}}};
    localparam logic [OCT_W-1:0] LIM_ERR = {{(OCT_W-ERR_W){1'b0}}, {ERR_W{1'b1}}};

    a_r7_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> rd_valid);

    a_r7_valid_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> !rd_valid);

    a_r11_bad_port_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && 32'(rd_port) >= NPORTS) |=> (rd_data == '0));

    a_r10_err_ceiling: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && rd_sel == C_INB_ERR) |=> (rd_data <= LIM_ERR));

    a_r10_pkt_ceiling: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && rd_sel != C_INB_OCT && rd_sel != C_INB_ERR) |=> (rd_data <= LIM_PKT));

    a_r8_clear_rereads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && $past(rd_en && rd_clr) && rd_port == $past(rd_port)
         && rd_sel == $past(rd_sel) && !$past(ev_valid && ev_port == rd_port))
        |=> (rd_data == '0));
endmodule

bind rxstat_counters rxstat_checker #(
    .NPORTS(NPORTS), .PORT_W(PORT_W), .PKT_W(PKT_W), .OCT_W(OCT_W), .ERR_W(ERR_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_port(ev_port),
    .rd_en(rd_en), .rd_clr(rd_clr), .rd_port(rd_port), .rd_sel(rd_sel),
    .rd_valid(rd_valid), .rd_data(rd_data)
);

// File: tb/rxstat_counters_tb.sv
module rxstat_counters_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NP   = 6;
    localparam int NC   = 21;
    localparam int PW   = 3;
    localparam int LW   = 14;
    localparam int PKTW = 16;
    localparam int OCTW = 20;
    localparam int ERRW = 4;

    typedef struct packed {
        logic [PW-1:0] port;
        logic [LW-1:0] len;
        logic fcs, rxe, drop, mc, bc, l2;
    } ev_t;

    // port, len, fcs, rxe, drop, mcast, bcast, l2
    localparam ev_t TBL [19] = '{
        '{3'd0, 14'd64,   1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1},
        '{3'd0, 14'd65,   1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1},
        '{3'd0, 14'd127,  1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1},
        '{3'd0, 14'd128,  1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1},
        '{3'd0, 14'd300,  1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0},
        '{3'd0, 14'd600,  1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1},
        '{3'd0, 14'd1024, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1},
        '{3'd0, 14'd1518, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1},
        '{3'd0, 14'd1519, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1},
        '{3'd0, 14'd1536, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1},
        '{3'd0, 14'd1537, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1},
        '{3'd0, 14'd2000, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1},
        '{3'd0, 14'd63,   1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1},
        '{3'd0, 14'd40,   1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1},
        '{3'd1, 14'd256,  1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1},
        '{3'd1, 14'd511,  1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1},
        '{3'd1, 14'd512,  1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1},
        '{3'd1, 14'd1023, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1},
        '{3'd6, 14'd100,  1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1}
    };

    logic clk = 1'b0, rst_n = 1'b0;
    logic ev_valid = 1'b0, ev_fcs_err = 1'b0, ev_rx_err = 1'b0, ev_drop = 1'b0;
    logic ev_mcast = 1'b0, ev_bcast = 1'b0, ev_l2 = 1'b0;
    logic [PW-1:0] ev_port = '0, rd_port = '0;
    logic [LW-1:0] ev_len = '0;
    logic rd_en = 1'b0, rd_clr = 1'b0;
    logic [4:0] rd_sel = '0;
    logic rd_valid;
    logic [OCTW-1:0] rd_data;

    int checks = 0, failures = 0;
    bit done = 1'b0;
    longint mdl [NP][NC];

    always #(CLK_PERIOD/2) clk = ~clk;

    rxstat_counters #(
        .NPORTS(NP), .LEN_W(LW), .PKT_W(PKTW), .OCT_W(OCTW), .ERR_W(ERRW),
        .MIN_LEN(64), .MAX_LEN(1536)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_port(ev_port),
        .ev_len(ev_len), .ev_fcs_err(ev_fcs_err), .ev_rx_err(ev_rx_err),
        .ev_drop(ev_drop), .ev_mcast(ev_mcast), .ev_bcast(ev_bcast), .ev_l2(ev_l2),
        .rd_en(rd_en), .rd_clr(rd_clr), .rd_port(rd_port), .rd_sel(rd_sel),
        .rd_valid(rd_valid), .rd_data(rd_data)
    );

    function automatic longint lim(int i);
        if (i == 19) return (64'd1 << OCTW) - 1;
        if (i == 20) return (64'd1 << ERRW) - 1;
        return (64'd1 << PKTW) - 1;
    endfunction

    function automatic longint inc_of(int i, ev_t e);
        longint n = longint'(e.len);
        bit runt = n < 64, over = n > 1536, mid = !runt && !over;
        case (i)
            0:  return e.drop ? 1 : 0;
            1:  return e.drop ? n : 0;
            2:  return !e.drop ? 1 : 0;
            3:  return !e.drop ? n : 0;
            4:  return (e.l2 && e.mc && !e.bc) ? 1 : 0;
            5:  return (e.l2 && e.bc) ? 1 : 0;
            6:  return (mid && n <= 64) ? 1 : 0;
            7:  return (mid && n >= 65 && n <= 127) ? 1 : 0;
            8:  return (mid && n >= 128 && n <= 255) ? 1 : 0;
            9:  return (mid && n >= 256 && n <= 511) ? 1 : 0;
            10: return (mid && n >= 512 && n <= 1023) ? 1 : 0;
            11: return (mid && n >= 1024 && n <= 1518) ? 1 : 0;
            12: return (mid && n >= 1519) ? 1 : 0;
            13: return e.fcs ? 1 : 0;
            14: return (runt && !e.fcs) ? 1 : 0;
            15: return (runt && e.fcs) ? 1 : 0;
            16: return (over && !e.fcs) ? 1 : 0;
            17: return (over && e.fcs) ? 1 : 0;
            18: return !e.rxe ? 1 : 0;
            19: return n;
            default: return e.rxe ? 1 : 0;
        endcase
    endfunction

    function automatic string tag_of(int i);
        if (i <= 3)  return "R5";
        if (i <= 5)  return "R2";
        if (i <= 12) return "R1";
        if (i == 13) return "R4";
        if (i <= 17) return "R3";
        return "R6";
    endfunction

    function automatic longint sat(longint v, int i);
        return (v > lim(i)) ? lim(i) : v;
    endfunction

    task automatic check(string req, longint got, longint exp, string what);
        checks++;
        if (got != exp) begin
            failures++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, got, exp);
        end
    endtask

    task automatic drive_ev(ev_t e);
        ev_valid = 1'b1; ev_port = e.port; ev_len = e.len;
        ev_fcs_err = e.fcs; ev_rx_err = e.rxe; ev_drop = e.drop;
        ev_mcast = e.mc; ev_bcast = e.bc; ev_l2 = e.l2;
    endtask

    task automatic model_ev(ev_t e, bit cleared, int csel);
        if (int'(e.port) < NP)
            for (int i = 0; i < NC; i++)
                mdl[e.port][i] = sat(((cleared && i == csel) ? 0 : mdl[e.port][i])
                                     + inc_of(i, e), i);
    endtask

    task automatic send(ev_t e);
        @(negedge clk);
        drive_ev(e);
        model_ev(e, 1'b0, -1);
        @(negedge clk);
        ev_valid = 1'b0;
    endtask

    task automatic do_read(int port, int sel, bit clr, output longint v);
        @(negedge clk);
        rd_en = 1'b1; rd_clr = clr; rd_port = PW'(port); rd_sel = 5'(sel);
        @(negedge clk);
        rd_en = 1'b0; rd_clr = 1'b0;
        v = longint'(rd_data);
        if (clr && port < NP && sel < NC) mdl[port][sel] = 0;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        longint v, old;
        ev_t e;
        for (int p = 0; p < NP; p++)
            for (int i = 0; i < NC; i++) mdl[p][i] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R7", longint'(rd_valid), 0, "rd_valid after reset");
        do_read(0, 0, 1'b0, v);
        check("R7", v, 0, "reset counter value");
        check("R7", longint'(rd_valid), 1, "rd_valid after read");
        @(negedge clk);
        check("R7", longint'(rd_valid), 0, "rd_valid idle");

        for (int k = 0; k < 19; k++) send(TBL[k]);

        for (int p = 0; p < 3; p++)
            for (int i = 0; i < NC; i++) begin
                do_read(p, i, 1'b0, v);
                check((p == 2) ? "R12" : tag_of(i), v, mdl[p][i],
                      $sformatf("port %0d counter %0d", p, i));
            end

        // R11: port 7 and counter index 25 read zero
        do_read(7, 2, 1'b0, v);
        check("R11", v, 0, "out-of-range port read");
        do_read(0, 25, 1'b0, v);
        check("R11", v, 0, "out-of-range counter read");

        // R8: plain read keeps, clearing read zeroes
        do_read(0, 19, 1'b0, v);
        check("R8", v, mdl[0][19], "read without clear");
        do_read(0, 19, 1'b0, v);
        check("R8", v, mdl[0][19], "value kept after plain read");
        do_read(0, 19, 1'b1, v);
        do_read(0, 19, 1'b0, v);
        check("R8", v, 0, "value after clearing read");

        // R9: clear and increment at the same edge
        e = '{3'd1, 14'd100, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1};
        old = mdl[1][2];
        @(negedge clk);
        drive_ev(e);
        rd_en = 1'b1; rd_clr = 1'b1; rd_port = 3'd1; rd_sel = 5'd2;
        model_ev(e, 1'b1, 2);
        @(negedge clk);
        ev_valid = 1'b0; rd_en = 1'b0; rd_clr = 1'b0;
        check("R9", longint'(rd_data), old, "collision returned value");
        do_read(1, 2, 1'b0, v);
        check("R9", v, 1, "collision leaves increment");
        do_read(1, 3, 1'b0, v);
        check("R9", v, mdl[1][3], "octets of collision event");

        // R10: saturation of error count and of a length sum
        e = '{3'd2, 14'd70, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1};
        for (int k = 0; k < 20; k++) send(e);
        do_read(2, 20, 1'b0, v);
        check("R10", v, 15, "error counter ceiling");
        e = '{3'd3, 14'd1536, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1};
        for (int k = 0; k < 50; k++) send(e);
        do_read(3, 3, 1'b0, v);
        check("R10", v, 65535, "octet counter ceiling");
        do_read(3, 19, 1'b0, v);
        check("R10", v, 76800, "wide octet counter no ceiling");
        do_read(3, 2, 1'b0, v);
        check("R10", v, 50, "packet counter below ceiling");

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule